// File: doc/BRIEF.md
# Multi-Issue Operation Scheduler Buffer

This block is the central holding station between instruction decode and the execution units. Decoded operations arrive in groups of up to four per cycle. Each operation carries a class code, two source register tags with ready flags, and a destination tag drawn from a pool of 48 physical registers. The operations wait in a circular buffer of twenty-four slots until both sources are ready. Each cycle, every one of six typed execution ports takes the oldest ready operation of its own class, so up to six operations leave together.

A writeback broadcast of a destination tag marks every matching source as ready. The execution side reports finished operations by slot index. The buffer then retires finished operations strictly from the oldest end, up to four per cycle, and frees their slots. A flush input empties the buffer in a single cycle.

The decode side uses a valid/ready handshake with back-pressure. `in_ready` is high when `in_count` is no greater than the number of free slots and no flush is in progress. A group moves only in a cycle with both `in_valid` and `in_ready` high, and it moves as a whole. While `in_ready` is low, the producer holds the group steady and nothing of it is stored. Issue and retire outputs carry no back-pressure: each execution port accepts whatever is presented to it.

Top module: `sched_buffer`

## Requirements
- R1: The buffer never holds more than DEPTH operations. `in_ready` is high exactly when `in_count` is at most the number of free slots and `flush` is low. An offered group that is not accepted leaves no trace in the issue outputs.
- R2: An accepted group of N operations (N at most ENQ_W) takes consecutive slots in lane order, starting at the allocation pointer. The slot index wraps from DEPTH-1 to 0. After reset or flush the first slot is 0.
- R3: Class codes are 0 memory load, 1 memory store, 2 complex integer or multimedia, 3 simple integer, 4 floating point and 5 branch condition evaluation. An operation whose two sources are ready issues only on the port whose number equals its class code, at the earliest in the cycle after acceptance. An operation with any source not ready does not issue.
- R4: Each port issues at most one operation per cycle, so all six ports may issue in the same cycle.
- R5: When several ready operations share a class, the port takes the oldest in allocation order, counted from the oldest live slot and not by raw slot index.
- R6: An operation issues exactly once. The cycle after it issues, its port no longer presents it.
- R7: A writeback with `wb_valid` high sets the ready flag of every held source whose tag equals `wb_tag`, effective from the next cycle. This also applies to an operation accepted in the same cycle as the broadcast.
- R8: `cmp_valid[c]` with `cmp_idx[c]` marks that held slot complete. Starting at the oldest slot, the longest run of complete slots, capped at RET_W, is shown on `ret_valid` and `ret_dst` in that cycle, oldest on lane 0. Those slots are freed at the next clock edge.
- R9: Retirement stops at the first incomplete slot. Complete slots younger than an incomplete one are not retired.
- R10: While `flush` is high, `in_ready`, `iss_valid` and `ret_valid` are low. At the clock edge the buffer empties and both pointers return to slot 0. An operation offered during the flush is not stored.
- R11: After synchronous reset the buffer is empty: no issue, no retire, and `in_ready` is high for any group size up to ENQ_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Discard all held operations this cycle |
| in_valid | input | 1 | Decode group offered |
| in_ready | output | 1 | Group of `in_count` operations can be taken |
| in_count | input | $clog2(ENQ_W+1) | Number of valid lanes in the group, lanes 0 upward |
| in_cls | input | ENQ_W x 3 | Class code per lane |
| in_src1 | input | ENQ_W x TAG_W | First source tag per lane |
| in_src1_rdy | input | ENQ_W | First source already available |
| in_src2 | input | ENQ_W x TAG_W | Second source tag per lane |
| in_src2_rdy | input | ENQ_W | Second source already available |
| in_dst | input | ENQ_W x TAG_W | Destination tag per lane |
| wb_valid | input | 1 | Writeback broadcast present |
| wb_tag | input | TAG_W | Tag being written back |
| cmp_valid | input | CMP_W | Completion report per lane |
| cmp_idx | input | CMP_W x IDX_W | Slot index reported complete |
| iss_valid | output | 6 | Port p issues this cycle |
| iss_idx | output | 6 x IDX_W | Slot index issued per port |
| iss_dst | output | 6 x TAG_W | Destination tag issued per port |
| ret_valid | output | RET_W | Retire lanes, a run from lane 0 |
| ret_dst | output | RET_W x TAG_W | Destination tag per retiring lane, oldest first |

## Verification
The bench builds the buffer with DEPTH set to 8 and keeps four decode lanes, four retire lanes, two completion lanes and 48 register tags. The small depth lets two groups fill the buffer, so the stall at exact capacity is reached quickly. It also lets the allocation pointer wrap after one earlier group has retired, which puts the oldest ready slot at a higher index than a younger one. With four retire lanes and six finished operations, both the cap on retirement width and a retirement run blocked by an incomplete head show up within a few cycles.

// File: rtl/sched_pkg.sv
`timescale 1ns/1ps
package sched_pkg;

  localparam int NUM_CLASSES = 6;
  localparam int CLS_W       = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_LOAD   = 3'd0,
    CLS_STORE  = 3'd1,
    CLS_CPLX   = 3'd2,
    CLS_SIMPLE = 3'd3,
    CLS_FLOAT  = 3'd4,
    CLS_BRANCH = 3'd5
  } op_class_e;

  // base + step on a ring of `depth` slots, with step below depth
  function automatic int unsigned ring_add(input int unsigned base,
                                           input int unsigned step,
                                           input int unsigned depth);
    int unsigned s;
    s = base + step;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

endpackage

// File: rtl/sched_pick.sv
`timescale 1ns/1ps
module sched_pick #(
  parameter int DEPTH = 24,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0] head,
  input  logic [DEPTH-1:0] req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  import sched_pkg::*;

  // walk the ring from the oldest slot; first requester wins
  always_comb begin
    logic [IDX_W-1:0] pos;
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      pos = IDX_W'(ring_add(32'(head), k, DEPTH));
      if (!found && req[pos]) begin
        found = 1'b1;
        idx   = pos;
      end
    end
  end

  // R5: the chosen slot is a requester, and nothing is chosen without one
  always_comb begin
    assert_pick_valid_R5: assert (found ? req[idx] : (req == '0));
  end

endmodule

// File: rtl/sched_retire.sv
`timescale 1ns/1ps
module sched_retire #(
  parameter int DEPTH  = 24,
  parameter int RET_W  = 4,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int RET_CW = $clog2(RET_W+1)
) (
  input  logic [IDX_W-1:0] head,
  input  logic [DEPTH-1:0] done,
  output logic [RET_W-1:0] ret_vec,
  output logic [IDX_W-1:0] ret_pos [RET_W],
  output logic [RET_CW-1:0] ret_n
);
  import sched_pkg::*;

  always_comb begin
    logic run;
    int   n;
    run     = 1'b1;
    n       = 0;
    ret_vec = '0;
    for (int k = 0; k < RET_W; k++) begin
      ret_pos[k] = IDX_W'(ring_add(32'(head), k, DEPTH));
      if (run && done[ret_pos[k]]) begin
        ret_vec[k] = 1'b1;
        n          = n + 1;
      end else begin
        run = 1'b0;
      end
    end
    ret_n = RET_CW'(n);
  end

  // R9: a retire lane is only used when every older lane is used too
  always_comb begin
    for (int k = 1; k < RET_W; k++) begin
      assert_ret_run_R9: assert (!ret_vec[k] || ret_vec[k-1]);
    end
  end

endmodule

// File: rtl/sched_ctrl.sv
`timescale 1ns/1ps
module sched_ctrl #(
  parameter int DEPTH  = 24,
  parameter int ENQ_W  = 4,
  parameter int RET_W  = 4,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH+1),
  parameter int ENQ_CW = $clog2(ENQ_W+1),
  parameter int RET_CW = $clog2(RET_W+1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [ENQ_CW-1:0] in_count,
  input  logic [RET_CW-1:0] ret_n,
  output logic              in_ready,
  output logic              accept,
  output logic [IDX_W-1:0]  head,
  output logic [IDX_W-1:0]  tail
);
  import sched_pkg::*;

  logic [CNT_W-1:0]  occ;
  logic [CNT_W-1:0]  free_n;
  logic [ENQ_CW-1:0] acc_n;

  assign free_n   = CNT_W'(DEPTH) - occ;
  assign in_ready = !flush && (32'(in_count) <= 32'(free_n));
  assign accept   = in_valid && in_ready;
  assign acc_n    = accept ? in_count : '0;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else begin
      head <= IDX_W'(ring_add(32'(head), 32'(ret_n), DEPTH));
      tail <= IDX_W'(ring_add(32'(tail), 32'(acc_n), DEPTH));
      occ  <= CNT_W'(32'(occ) + 32'(acc_n) - 32'(ret_n));
    end
  end

  // R1: occupancy never passes the capacity
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
    32'(occ) <= DEPTH);

  // R2: the allocation pointer sits occ slots past the oldest slot
  assert_ptr_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (32'(occ) < DEPTH) |-> (32'(tail) == ring_add(32'(head), 32'(occ), DEPTH)));

  // R2: groups never exceed the lane count
  assert_group_size_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (32'(in_count) <= ENQ_W));

  // R8: retiring operations moves the oldest-slot pointer
  assert_head_moves_R8: assert property (@(posedge clk) disable iff (rst)
    (ret_n != '0 && !flush && 32'(ret_n) < DEPTH) |=> (head != $past(head)));

  // R10: a flush leaves the buffer empty with pointers at slot 0
  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (occ == '0 && head == '0 && tail == '0));

endmodule

// File: rtl/sched_buffer.sv
`timescale 1ns/1ps
module sched_buffer
  import sched_pkg::*;
#(
  parameter int DEPTH     = 24,
  parameter int ENQ_W     = 4,
  parameter int RET_W     = 4,
  parameter int CMP_W     = 2,
  parameter int NUM_PREGS = 48,
  localparam int TAG_W    = $clog2(NUM_PREGS),
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int ENQ_CW   = $clog2(ENQ_W+1),
  localparam int RET_CW   = $clog2(RET_W+1),
  localparam int NP       = NUM_CLASSES
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        flush,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [ENQ_CW-1:0]           in_count,
  input  logic [ENQ_W-1:0][CLS_W-1:0] in_cls,
  input  logic [ENQ_W-1:0][TAG_W-1:0] in_src1,
  input  logic [ENQ_W-1:0]            in_src1_rdy,
  input  logic [ENQ_W-1:0][TAG_W-1:0] in_src2,
  input  logic [ENQ_W-1:0]            in_src2_rdy,
  input  logic [ENQ_W-1:0][TAG_W-1:0] in_dst,
  input  logic                        wb_valid,
  input  logic [TAG_W-1:0]            wb_tag,
  input  logic [CMP_W-1:0]            cmp_valid,
  input  logic [CMP_W-1:0][IDX_W-1:0] cmp_idx,
  output logic [NP-1:0]               iss_valid,
  output logic [NP-1:0][IDX_W-1:0]    iss_idx,
  output logic [NP-1:0][TAG_W-1:0]    iss_dst,
  output logic [RET_W-1:0]            ret_valid,
  output logic [RET_W-1:0][TAG_W-1:0] ret_dst
);

  // slot state
  logic [DEPTH-1:0] ent_valid, ent_issued, ent_done;
  logic [DEPTH-1:0] ent_r1, ent_r2;
  logic [CLS_W-1:0] ent_cls [DEPTH];
  logic [TAG_W-1:0] ent_s1  [DEPTH];
  logic [TAG_W-1:0] ent_s2  [DEPTH];
  logic [TAG_W-1:0] ent_dst [DEPTH];

  logic              accept;
  logic [IDX_W-1:0]  head, tail;
  logic [RET_CW-1:0] ret_n, ret_n_eff;
  logic [RET_W-1:0]  ret_vec;
  logic [IDX_W-1:0]  ret_pos [RET_W];

  logic [NP-1:0][DEPTH-1:0] req;
  logic [NP-1:0]            pick_found;
  logic [NP-1:0][IDX_W-1:0] pick_idx;

  logic [IDX_W-1:0] apos   [ENQ_W];
  logic [ENQ_W-1:0] alloc_en;

  // pointer and occupancy control
  sched_ctrl #(
    .DEPTH(DEPTH), .ENQ_W(ENQ_W), .RET_W(RET_W)
  ) i_ctrl (
    .clk(clk), .rst(rst), .flush(flush),
    .in_valid(in_valid), .in_count(in_count), .ret_n(ret_n_eff),
    .in_ready(in_ready), .accept(accept), .head(head), .tail(tail)
  );

  // allocation lanes
  always_comb begin
    for (int j = 0; j < ENQ_W; j++) begin
      apos[j]     = IDX_W'(ring_add(32'(tail), j, DEPTH));
      alloc_en[j] = accept && (32'(in_count) > j);
    end
  end

  // per-class request vectors
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      for (int e = 0; e < DEPTH; e++) begin
        req[p][e] = ent_valid[e] && !ent_issued[e] && ent_r1[e] && ent_r2[e]
                    && (ent_cls[e] == CLS_W'(p));
      end
    end
  end

  // one oldest-first picker per execution port
  for (genvar p = 0; p < NP; p++) begin : g_port
    sched_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_pick (
      .head(head), .req(req[p]), .found(pick_found[p]), .idx(pick_idx[p])
    );
    assign iss_valid[p] = pick_found[p] && !flush;
    assign iss_idx[p]   = pick_idx[p];
    assign iss_dst[p]   = ent_dst[pick_idx[p]];

    // R3: a port only carries operations of its own class
    assert_port_class_R3: assert property (@(posedge clk) disable iff (rst)
      iss_valid[p] |-> (ent_valid[iss_idx[p]] && 32'(ent_cls[iss_idx[p]]) == p));

    // R6: the same slot is not presented twice in a row on a port
    assert_single_issue_R6: assert property (@(posedge clk) disable iff (rst)
      (iss_valid[p] && !flush) |=> !(iss_valid[p] && iss_idx[p] == $past(iss_idx[p])));
  end

  // in-order retirement from the oldest slot
  sched_retire #(.DEPTH(DEPTH), .RET_W(RET_W), .IDX_W(IDX_W)) i_retire (
    .head(head), .done(ent_valid & ent_done),
    .ret_vec(ret_vec), .ret_pos(ret_pos), .ret_n(ret_n)
  );

  assign ret_n_eff = flush ? '0 : ret_n;
  assign ret_valid = flush ? '0 : ret_vec;

  always_comb begin
    for (int k = 0; k < RET_W; k++) ret_dst[k] = ent_dst[ret_pos[k]];
  end

  // slot state update
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      ent_valid  <= '0;
      ent_issued <= '0;
      ent_done   <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (wb_valid && ent_s1[e] == wb_tag) ent_r1[e] <= 1'b1;
        if (wb_valid && ent_s2[e] == wb_tag) ent_r2[e] <= 1'b1;
      end
      for (int p = 0; p < NP; p++) begin
        if (iss_valid[p]) ent_issued[iss_idx[p]] <= 1'b1;
      end
      for (int c = 0; c < CMP_W; c++) begin
        if (cmp_valid[c] && 32'(cmp_idx[c]) < DEPTH && ent_valid[cmp_idx[c]])
          ent_done[cmp_idx[c]] <= 1'b1;
      end
      for (int k = 0; k < RET_W; k++) begin
        if (ret_vec[k]) ent_valid[ret_pos[k]] <= 1'b0;
      end
      for (int j = 0; j < ENQ_W; j++) begin
        if (alloc_en[j]) begin
          ent_valid[apos[j]]  <= 1'b1;
          ent_issued[apos[j]] <= 1'b0;
          ent_done[apos[j]]   <= 1'b0;
          ent_cls[apos[j]]    <= in_cls[j];
          ent_s1[apos[j]]     <= in_src1[j];
          ent_s2[apos[j]]     <= in_src2[j];
          ent_dst[apos[j]]    <= in_dst[j];
          ent_r1[apos[j]]     <= in_src1_rdy[j] || (wb_valid && in_src1[j] == wb_tag);
          ent_r2[apos[j]]     <= in_src2_rdy[j] || (wb_valid && in_src2[j] == wb_tag);
        end
      end
    end
  end

  // R3: accepted lanes carry a known class code
  for (genvar j = 0; j < ENQ_W; j++) begin : g_lane_chk
    assert_class_code_R3: assert property (@(posedge clk) disable iff (rst)
      alloc_en[j] |-> (32'(in_cls[j]) < NP));
  end

  // R4: issue count never exceeds the number of waiting operations
  assert_issue_bound_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(iss_valid) <= $countones(ent_valid & ~ent_issued));

  // R7: a broadcast readies matching sources of held operations
  for (genvar e = 0; e < DEPTH; e++) begin : g_wake_chk
    assert_wakeup_src1_R7: assert property (@(posedge clk) disable iff (rst)
      (wb_valid && !flush && ent_valid[e] && ent_s1[e] == wb_tag) |=> ent_r1[e]);
    assert_wakeup_src2_R7: assert property (@(posedge clk) disable iff (rst)
      (wb_valid && !flush && ent_valid[e] && ent_s2[e] == wb_tag) |=> ent_r2[e]);
  end

  // R8: a retire lane names a held operation
  for (genvar k = 0; k < RET_W; k++) begin : g_ret_chk
    assert_ret_held_R8: assert property (@(posedge clk) disable iff (rst)
      ret_valid[k] |-> ent_valid[ret_pos[k]]);
  end

endmodule

// File: tb/test_sched_buffer.sv
`timescale 1ns/1ps
module test_sched_buffer;
  import sched_pkg::*;

  localparam int DEPTH = 8;
  localparam int ENQ_W = 4;
  localparam int RET_W = 4;
  localparam int CMP_W = 2;
  localparam int TAG_W = 6;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int NP    = NUM_CLASSES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_count = '0;
  logic [ENQ_W-1:0][2:0]       in_cls = '0;
  logic [ENQ_W-1:0][TAG_W-1:0] in_src1 = '0;
  logic [ENQ_W-1:0]            in_src1_rdy = '0;
  logic [ENQ_W-1:0][TAG_W-1:0] in_src2 = '0;
  logic [ENQ_W-1:0]            in_src2_rdy = '0;
  logic [ENQ_W-1:0][TAG_W-1:0] in_dst = '0;
  logic wb_valid = 1'b0;
  logic [TAG_W-1:0] wb_tag = '0;
  logic [CMP_W-1:0] cmp_valid = '0;
  logic [CMP_W-1:0][IDX_W-1:0] cmp_idx = '0;
  logic [NP-1:0] iss_valid;
  logic [NP-1:0][IDX_W-1:0] iss_idx;
  logic [NP-1:0][TAG_W-1:0] iss_dst;
  logic [RET_W-1:0] ret_valid;
  logic [RET_W-1:0][TAG_W-1:0] ret_dst;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  sched_buffer #(.DEPTH(DEPTH), .ENQ_W(ENQ_W), .RET_W(RET_W), .CMP_W(CMP_W)) i_sched_buffer (
    .clk(clk), .rst(rst), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_count(in_count),
    .in_cls(in_cls), .in_src1(in_src1), .in_src1_rdy(in_src1_rdy),
    .in_src2(in_src2), .in_src2_rdy(in_src2_rdy), .in_dst(in_dst),
    .wb_valid(wb_valid), .wb_tag(wb_tag),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx),
    .iss_valid(iss_valid), .iss_idx(iss_idx), .iss_dst(iss_dst),
    .ret_valid(ret_valid), .ret_dst(ret_dst)
  );

  // routing vectors: {class, src1 ready, src2 ready, expected port mask}
  localparam logic [10:0] VEC [8] = '{
    {CLS_LOAD,   2'b11, 6'h01},
    {CLS_STORE,  2'b11, 6'h02},
    {CLS_CPLX,   2'b11, 6'h04},
    {CLS_SIMPLE, 2'b11, 6'h08},
    {CLS_FLOAT,  2'b11, 6'h10},
    {CLS_BRANCH, 2'b11, 6'h20},
    {CLS_CPLX,   2'b01, 6'h00},
    {CLS_FLOAT,  2'b10, 6'h00}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(input int j, input int cls, input int s1, input bit r1,
                     input int s2, input bit r2, input int dst);
    in_cls[j]      = 3'(cls);
    in_src1[j]     = TAG_W'(s1);
    in_src1_rdy[j] = r1;
    in_src2[j]     = TAG_W'(s2);
    in_src2_rdy[j] = r2;
    in_dst[j]      = TAG_W'(dst);
  endtask

  task automatic idle();
    in_valid  = 1'b0;
    in_count  = '0;
    wb_valid  = 1'b0;
    cmp_valid = '0;
    flush     = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11: reset state
    in_count = 3'd4;
    #1;
    chk("R11 in_ready after reset", int'(in_ready), 1);
    chk("R11 no issue after reset", int'(iss_valid), 0);
    chk("R11 no retire after reset", int'(ret_valid), 0);
    in_count = '0;
    @(negedge clk);

    // R3: routing table
    for (int i = 0; i < 8; i++) begin
      do_flush();
      put(0, int'(VEC[i][10:8]), 1, VEC[i][7], 2, VEC[i][6], 20 + i);
      in_count = 3'd1;
      in_valid = 1'b1;
      @(negedge clk);
      idle();
      chk("R3 port mask", int'(iss_valid), int'(VEC[i][5:0]));
      if (VEC[i][5:0] != 6'h00) begin
        chk("R3 issued dst", int'(iss_dst[VEC[i][10:8]]), 20 + i);
        chk("R2 first slot after flush", int'(iss_idx[VEC[i][10:8]]), 0);
      end
    end

    // R4, R7, R2, R6: six classes waiting on one tag, woken together
    do_flush();
    for (int j = 0; j < 4; j++) put(j, j, 40, 1'b0, 3, 1'b1, 30 + j);
    in_count = 3'd4;
    in_valid = 1'b1;
    @(negedge clk);
    put(0, 4, 40, 1'b0, 3, 1'b1, 34);
    put(1, 5, 40, 1'b0, 3, 1'b1, 35);
    in_count = 3'd2;
    @(negedge clk);
    idle();
    chk("R7 waits for source", int'(iss_valid), 0);
    wb_valid = 1'b1;
    wb_tag   = TAG_W'(40);
    @(negedge clk);
    idle();
    chk("R4 six ports together", int'(iss_valid), 6'h3F);
    for (int p = 0; p < NP; p++) begin
      chk("R2 slot order", int'(iss_idx[p]), p);
      chk("R3 dst per port", int'(iss_dst[p]), 30 + p);
    end
    @(negedge clk);
    chk("R6 no second issue", int'(iss_valid), 0);

    // R9, R8: complete younger first, then the head
    cmp_valid = 2'b11; cmp_idx[0] = 3'd1; cmp_idx[1] = 3'd2;
    @(negedge clk);
    chk("R9 head incomplete blocks", int'(ret_valid), 0);
    cmp_idx[0] = 3'd3; cmp_idx[1] = 3'd4;
    @(negedge clk);
    cmp_valid = 2'b01; cmp_idx[0] = 3'd5;
    @(negedge clk);
    chk("R9 still blocked", int'(ret_valid), 0);
    cmp_idx[0] = 3'd0;
    @(negedge clk);
    idle();
    chk("R8 retire capped at four", int'(ret_valid), 4'hF);
    for (int k = 0; k < RET_W; k++) chk("R8 retire order", int'(ret_dst[k]), 30 + k);
    @(negedge clk);
    chk("R8 remaining two", int'(ret_valid), 4'h3);
    chk("R8 lane0 dst", int'(ret_dst[0]), 34);
    chk("R8 lane1 dst", int'(ret_dst[1]), 35);
    @(negedge clk);
    chk("R8 nothing left", int'(ret_valid), 0);

    // R1, R5: wrap-around fill (oldest slot is 6)
    put(0, 3, 41, 1'b0, 3, 1'b1, 50);
    put(1, 3, 42, 1'b0, 3, 1'b1, 51);
    put(2, 3, 42, 1'b0, 3, 1'b1, 52);
    put(3, 3, 42, 1'b0, 3, 1'b1, 53);
    in_count = 3'd4;
    in_valid = 1'b1;
    @(negedge clk);
    for (int j = 0; j < 4; j++) put(j, 5, 45, 1'b0, 3, 1'b1, 54 + j);
    #1;
    chk("R1 exact fill accepted", int'(in_ready), 1);
    @(negedge clk);
    put(0, 0, 3, 1'b1, 3, 1'b1, 60);
    in_count = 3'd1;
    #1;
    chk("R1 full stalls", int'(in_ready), 0);
    @(negedge clk);
    idle();
    chk("R1 stalled op not stored", int'(iss_valid), 0);
    wb_valid = 1'b1;
    wb_tag   = TAG_W'(42);
    @(negedge clk);
    idle();
    chk("R5 port3 issues", int'(iss_valid), 6'h08);
    chk("R5 oldest across wrap", int'(iss_idx[3]), 7);
    chk("R5 oldest dst", int'(iss_dst[3]), 51);
    @(negedge clk);
    chk("R5 next oldest", int'(iss_idx[3]), 0);
    @(negedge clk);
    chk("R5 third", int'(iss_idx[3]), 1);
    wb_valid = 1'b1;
    wb_tag   = TAG_W'(41);
    @(negedge clk);
    idle();
    chk("R7 late wakeup slot", int'(iss_idx[3]), 6);
    chk("R7 late wakeup dst", int'(iss_dst[3]), 50);

    // R10: flush with pending issue and an offered op
    flush = 1'b1;
    put(0, 0, 3, 1'b1, 3, 1'b1, 61);
    in_count = 3'd1;
    in_valid = 1'b1;
    #1;
    chk("R10 in_ready low in flush", int'(in_ready), 0);
    chk("R10 issue masked in flush", int'(iss_valid), 0);
    chk("R10 retire masked in flush", int'(ret_valid), 0);
    @(negedge clk);
    idle();
    @(negedge clk);
    chk("R10 offered op dropped", int'(iss_valid), 0);
    in_count = 3'd4;
    #1;
    chk("R10 empty after flush", int'(in_ready), 1);

    // R7: wakeup bypass on the accepting cycle
    put(0, 4, 43, 1'b0, 3, 1'b1, 62);
    in_count = 3'd1;
    in_valid = 1'b1;
    wb_valid = 1'b1;
    wb_tag   = TAG_W'(43);
    @(negedge clk);
    idle();
    chk("R7 bypass issue", int'(iss_valid), 6'h10);
    chk("R10 pointer back at 0", int'(iss_idx[4]), 0);
    chk("R7 bypass dst", int'(iss_dst[4]), 62);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule